// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is the shift/rotate datapath of a classic CISC integer core. In one pass it applies one of four operations (arithmetic shift, logical shift, rotate through the extend flag, plain rotate), either left or right, to an 8-, 16- or 32-bit operand. It also produces the updated condition flags and the number of bus cycles the instruction costs. Operand fetch, register file and instruction decode are outside the block. The caller presents the already-decoded fields together with a one-cycle `in_valid` strobe, and collects the registered result one cycle later.

The count comes from one of three places: a 3-bit immediate, the low six bits of a register value, or the memory form. The memory form always shifts a 16-bit word by one place. The work is done by a single-cycle barrel network, so the reported cycle count is the cost the instruction would have and does not reflect the latency of this block.

Top module: `shift_rot_unit`

## Requirements
- R1: `op_kind` selects 0 = arithmetic shift, 1 = logical shift, 2 = rotate through X, 3 = plain rotate. `op_left` = 1 means left and 0 means right. Arithmetic right fills with the sign bit of the selected width; logical shifts fill with zeros.
- R2: With `cnt_from_reg` = 0 the count is `cnt_imm`, where 0 stands for 8, so the range is 1 to 8. With `cnt_from_reg` = 1 the count is `cnt_reg` modulo 64.
- R3: Flag V (`flags_out[1]`) is set by an arithmetic left shift only when the most significant bit of the width changes at any step of the shift. This includes counts at or above the width. Every other operation clears V.
- R4: For arithmetic and logical shifts with a nonzero count, C and X both take the last bit shifted out. Past the width, that bit is 0, or the sign bit for arithmetic right.
- R5: For arithmetic and logical shifts with a zero count, C is cleared, X is kept, and the result equals the operand.
- R6: Rotate through X rotates the value together with X, a width+1 bit quantity, so the effective count is the count modulo width+1. When that is zero, C takes the old X and X is kept. Otherwise X = C = the last bit rotated out.
- R7: Plain rotate never changes X. C is the final bit 0 after a left rotate and the final top bit after a right rotate. A zero count clears C.
- R8: `cycles_out` = 6 for byte or word, or 8 for long, plus 2 for each count position (the count of R2, not reduced).
- R9: With `mem_form` = 1 the size is forced to word and the count to 1. The count fields are ignored, bits 31:16 pass through, and the cost is 8.
- R10: `op_size` selects 0 = byte, 1 = word, 2 or 3 = long. N is the top bit of the result at that width, and Z is set when the result at that width is zero. Bits above the width pass through unchanged. Flags are packed as `{X,N,Z,V,C}` in bits 4..0.
- R11: `out_valid` is high exactly in the cycle after each `in_valid` cycle. `result`, `flags_out` and `cycles_out` hold their values between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| in_valid | input | 1 | operation strobe |
| op_kind | input | 2 | operation type (R1) |
| op_left | input | 1 | 1 = left, 0 = right |
| op_size | input | 2 | operand width select (R10) |
| cnt_from_reg | input | 1 | take count from `cnt_reg` |
| cnt_imm | input | 3 | immediate count, 0 means 8 |
| cnt_reg | input | 32 | register count source, used modulo 64 |
| mem_form | input | 1 | single-bit word memory form |
| operand | input | 32 | value to shift |
| flags_in | input | 5 | current `{X,N,Z,V,C}` |
| out_valid | output | 1 | result valid |
| result | output | 32 | shifted value |
| flags_out | output | 5 | updated `{X,N,Z,V,C}` |
| cycles_out | output | 8 | instruction cost in cycles |

## Verification
The bound checker watches several rules on every operation. It checks the valid pipeline timing and that V is cleared outside arithmetic shifts. It also checks that X equals C after a nonzero shift, that a zero register count clears C and keeps X and the operand, and that plain rotate keeps X. It further covers the pass-through and cost of the memory form, and N and Z for long operands. The bench scenarios are the only place where the actual shifted values are checked. They are also the only place where the sticky sign-change rule for V, the modulo width+1 reduction of rotate through X, rotate carry at count multiples of the width, immediate 0 as 8, and the per-bit cycle totals are shown, by comparing against a bit-serial reference model.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} size_e;
  typedef enum logic [1:0] {OP_ASH = 2'd0, OP_LSH = 2'd1, OP_ROX = 2'd2, OP_ROT = 2'd3} kind_e;
  localparam int FX = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;
endpackage

// File: rtl/shrot_count_sel.sv
module shrot_count_sel
  import shrot_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int CYC_W = 8
) (
  input  logic             mem_form,
  input  logic [1:0]       size_in,
  input  logic             from_reg,
  input  logic [2:0]       imm,
  input  logic [CNT_W-1:0] reg_cnt,
  output size_e            size_eff,
  output logic [CNT_W-1:0] count,
  output logic [CYC_W-1:0] cycles
);
  localparam int BASE_SHORT = 6;
  localparam int BASE_LONG  = 8;

  always_comb begin
    if (mem_form) begin
      size_eff = SZ_WORD;
    end else begin
      case (size_in)
        2'd0:    size_eff = SZ_BYTE;
        2'd1:    size_eff = SZ_WORD;
        default: size_eff = SZ_LONG;
      endcase
    end

    if (mem_form)            count = CNT_W'(1);
    else if (from_reg)       count = reg_cnt;
    else if (imm == 3'd0)    count = CNT_W'(8);
    else                     count = CNT_W'(imm);

    cycles = CYC_W'((size_eff == SZ_LONG) ? BASE_LONG : BASE_SHORT)
           + CYC_W'({count, 1'b0});
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  kind_e             kind,
  input  logic              left,
  input  size_e             size,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] operand,
  input  logic              x_in,
  output logic [DATA_W-1:0] result,
  output logic              x_out,
  output logic              n_out,
  output logic              z_out,
  output logic              v_out,
  output logic              c_out
);
  localparam int EXT_W = 2 * DATA_W;
  localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

  logic [EXT_W-1:0] wid, mask, val, sval, nn, rr, t, zz, ones, res, res_m;
  logic [5:0]       msb;

  always_comb begin
    case (size)
      SZ_BYTE: begin wid = EXT_W'(8);  msb = 6'd7;  end
      SZ_WORD: begin wid = EXT_W'(16); msb = 6'd15; end
      default: begin wid = EXT_W'(32); msb = 6'd31; end
    endcase
    mask = (ONE << wid) - ONE;
    val  = EXT_W'(operand) & mask;
    sval = val[msb] ? (val | ~mask) : val;
    nn   = EXT_W'(count);
    res  = val;
    x_out = x_in;
    c_out = 1'b0;
    v_out = 1'b0;
    t    = '0;
    zz   = '0;
    ones = '0;
    rr   = '0;

    case (kind)
      OP_ASH, OP_LSH: begin
        if (nn != '0) begin
          if (left) begin
            t     = val << nn;
            res   = t;
            c_out = t[msb + 6'd1];
            if (kind == OP_ASH) begin
              if (nn >= wid) begin
                v_out = (val != '0);
              end else begin
                t     = val >> (wid - ONE - nn);
                ones  = (ONE << (nn + ONE)) - ONE;
                v_out = !((t == '0) || (t == ones));
              end
            end
          end else begin
            t     = (kind == OP_ASH) ? sval : val;
            res   = (kind == OP_ASH) ? EXT_W'($signed(t) >>> nn) : (t >> nn);
            c_out = t[count - CNT_W'(1)];
          end
          x_out = c_out;
        end
      end
      OP_ROT: begin
        case (size)
          SZ_BYTE: rr = EXT_W'(count[2:0]);
          SZ_WORD: rr = EXT_W'(count[3:0]);
          default: rr = EXT_W'(count[4:0]);
        endcase
        if (left) res = (val << rr) | (val >> (wid - rr));
        else      res = (val >> rr) | (val << (wid - rr));
        if (nn != '0) c_out = left ? res[0] : res[msb];
      end
      default: begin
        zz = val | (EXT_W'(x_in) << wid);
        rr = nn % (wid + ONE);
        if (left) res = (zz << rr) | (zz >> (wid + ONE - rr));
        else      res = (zz >> rr) | (zz << (wid + ONE - rr));
        c_out = res[msb + 6'd1];
        x_out = c_out;
      end
    endcase

    res_m  = res & mask;
    n_out  = res_m[msb];
    z_out  = (res_m == '0);
    result = (operand & ~mask[DATA_W-1:0]) | res_m[DATA_W-1:0];
  end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int CYC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_kind,
  input  logic              op_left,
  input  logic [1:0]        op_size,
  input  logic              cnt_from_reg,
  input  logic [2:0]        cnt_imm,
  input  logic [DATA_W-1:0] cnt_reg,
  input  logic              mem_form,
  input  logic [DATA_W-1:0] operand,
  input  logic [4:0]        flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        flags_out,
  output logic [CYC_W-1:0]  cycles_out
);
  size_e             size_eff;
  logic [CNT_W-1:0]  count;
  logic [CYC_W-1:0]  cyc_calc;
  logic [DATA_W-1:0] res_calc;
  logic              x_c, n_c, z_c, v_c, c_c;

  logic              valid_d;
  logic [DATA_W-1:0] result_d;
  logic [4:0]        flags_d;
  logic [CYC_W-1:0]  cycles_d;

  shrot_count_sel #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_cnt (
    .mem_form (mem_form),
    .size_in  (op_size),
    .from_reg (cnt_from_reg),
    .imm      (cnt_imm),
    .reg_cnt  (cnt_reg[CNT_W-1:0]),
    .size_eff (size_eff),
    .count    (count),
    .cycles   (cyc_calc)
  );

  shrot_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .kind    (kind_e'(op_kind)),
    .left    (op_left),
    .size    (size_eff),
    .count   (count),
    .operand (operand),
    .x_in    (flags_in[FX]),
    .result  (res_calc),
    .x_out   (x_c),
    .n_out   (n_c),
    .z_out   (z_c),
    .v_out   (v_c),
    .c_out   (c_c)
  );

  always_comb begin
    valid_d  = in_valid;
    result_d = result;
    flags_d  = flags_out;
    cycles_d = cycles_out;
    if (in_valid) begin
      result_d = res_calc;
      flags_d  = {x_c, n_c, z_c, v_c, c_c};
      cycles_d = cyc_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      flags_out  <= '0;
      cycles_out <= '0;
    end else begin
      out_valid  <= valid_d;
      result     <= result_d;
      flags_out  <= flags_d;
      cycles_out <= cycles_d;
    end
  end
endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  op_kind,
  input logic [1:0]  op_size,
  input logic        cnt_from_reg,
  input logic [5:0]  cnt_low,
  input logic        mem_form,
  input logic [31:0] operand,
  input logic [4:0]  flags_in,
  input logic        out_valid,
  input logic [31:0] result,
  input logic [4:0]  flags_out,
  input logic [7:0]  cycles_out
);
  logic zero_shift;
  assign zero_shift = in_valid && (op_kind[1] == 1'b0) && !mem_form
                      && cnt_from_reg && (cnt_low == 6'd0);

  p_valid_pipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_pipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_v_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind != 2'd0) |=> !flags_out[1]);
  p_rot_keeps_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd3) |=> flags_out[4] == $past(flags_in[4]));
  p_x_equals_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind[1] == 1'b0 && !zero_shift) |=> flags_out[4] == flags_out[0]);
  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_shift |=> (!flags_out[0] && flags_out[4] == $past(flags_in[4])
                    && result == $past(operand)));
  p_mem_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mem_form) |=> (result[31:16] == $past(operand[31:16])
                                && cycles_out == 8'd8));
  p_long_nz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mem_form && op_size[1]) |=> (flags_out[2] == (result == 32'd0)
                                              && flags_out[3] == result[31]));
endmodule

bind shift_rot_unit shift_rot_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .op_kind      (op_kind),
  .op_size      (op_size),
  .cnt_from_reg (cnt_from_reg),
  .cnt_low      (cnt_reg[5:0]),
  .mem_form     (mem_form),
  .operand      (operand),
  .flags_in     (flags_in),
  .out_valid    (out_valid),
  .result       (result),
  .flags_out    (flags_out),
  .cycles_out   (cycles_out)
);

// File: tb/shift_rot_unit_test.sv
module shift_rot_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_kind = '0;
  logic        op_left = 1'b0;
  logic [1:0]  op_size = '0;
  logic        cnt_from_reg = 1'b0;
  logic [2:0]  cnt_imm = '0;
  logic [31:0] cnt_reg = '0;
  logic        mem_form = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  flags_in = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [4:0]  flags_out;
  logic [7:0]  cycles_out;

  int errors = 0;
  int checks = 0;

  logic [31:0] q_res[$];
  logic [4:0]  q_fl[$];
  logic [7:0]  q_cyc[$];
  string       q_req[$];

  always #5 clk = ~clk;

  shift_rot_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
    .op_left(op_left), .op_size(op_size), .cnt_from_reg(cnt_from_reg),
    .cnt_imm(cnt_imm), .cnt_reg(cnt_reg), .mem_form(mem_form),
    .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
    .result(result), .flags_out(flags_out), .cycles_out(cycles_out)
  );

  // Bit-serial reference: one position per step, flags {X,N,Z,V,C}.
  function automatic void ref_model(
    input logic [1:0] k, input logic lf, input logic [1:0] sz, input logic fr,
    input logic [2:0] im, input logic [31:0] rc, input logic mm,
    input logic [31:0] opd, input logic [4:0] fi,
    output logic [31:0] r, output logic [4:0] fo, output logic [7:0] cy);
    int w;
    int n;
    logic [31:0] v, msk;
    logic x, c, vf, ob, top;
    w = mm ? 16 : (sz == 2'd0 ? 8 : (sz == 2'd1 ? 16 : 32));
    n = mm ? 1 : (fr ? int'(rc[5:0]) : (im == 3'd0 ? 8 : int'(im)));
    msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    v = opd & msk;
    x = fi[4]; c = 1'b0; vf = 1'b0;
    for (int i = 0; i < n; i++) begin
      top = v[w-1];
      if (lf) begin
        ob = v[w-1];
        v = (v << 1) & msk;
        if (k == 2'd2) v[0] = x;
        else if (k == 2'd3) v[0] = ob;
        if (k == 2'd0 && v[w-1] != top) vf = 1'b1;
      end else begin
        ob = v[0];
        v = v >> 1;
        if (k == 2'd0) v[w-1] = top;
        else if (k == 2'd2) v[w-1] = x;
        else if (k == 2'd3) v[w-1] = ob;
      end
      c = ob;
      if (k != 2'd3) x = ob;
    end
    if (n == 0 && k == 2'd2) c = x;
    r  = (opd & ~msk) | v;
    fo = {x, v[w-1], (v == 32'd0), vf, c};
    cy = 8'((w == 32 ? 8 : 6) + 2 * n);
  endfunction

  task automatic drive(input logic [1:0] k, input logic lf, input logic [1:0] sz,
                       input logic fr, input logic [2:0] im, input logic [31:0] rc,
                       input logic mm, input logic [31:0] opd, input logic [4:0] fi,
                       input string req);
    logic [31:0] r;
    logic [4:0]  fo;
    logic [7:0]  cy;
    @(negedge clk);
    op_kind = k; op_left = lf; op_size = sz; cnt_from_reg = fr; cnt_imm = im;
    cnt_reg = rc; mem_form = mm; operand = opd; flags_in = fi; in_valid = 1'b1;
    ref_model(k, lf, sz, fr, im, rc, mm, opd, fi, r, fo, cy);
    q_res.push_back(r); q_fl.push_back(fo); q_cyc.push_back(cy); q_req.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare each valid output against the front of the scoreboard.
  always @(posedge clk) begin
    #2;
    if (rst_n && out_valid) begin
      checks++;
      if (q_res.size() == 0) begin
        errors++;
        $display("FAIL R11: out_valid=1 with no pending operation (actual 1, expected 0)");
      end else begin
        logic [31:0] er;
        logic [4:0]  ef;
        logic [7:0]  ec;
        string       rq;
        er = q_res.pop_front(); ef = q_fl.pop_front();
        ec = q_cyc.pop_front(); rq = q_req.pop_front();
        if (result !== er || flags_out !== ef || cycles_out !== ec) begin
          errors++;
          $display("FAIL %s: actual res=%h fl=%b cyc=%0d expected res=%h fl=%b cyc=%0d",
                   rq, result, flags_out, cycles_out, er, ef, ec);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 32'd0 || flags_out !== 5'd0 || cycles_out !== 8'd0) begin
      errors++;
      $display("FAIL R11: reset state actual v=%b r=%h f=%b c=%0d expected all zero",
               out_valid, result, flags_out, cycles_out);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R3: arithmetic left of 0x40 by 1 flips the sign -> V set
    drive(2'd0, 1'b1, 2'd0, 1'b0, 3'd1, 32'd0, 1'b0, 32'h0000_0040, 5'b00000, "R1_R3");
    // R2: immediate 0 means 8, logical right word
    drive(2'd1, 1'b0, 2'd1, 1'b0, 3'd0, 32'd0, 1'b0, 32'h0000_8100, 5'b00000, "R2");
    // R2: register count 65 behaves as 1
    drive(2'd1, 1'b1, 2'd2, 1'b1, 3'd0, 32'd65, 1'b0, 32'h8000_0001, 5'b00000, "R2");
    // R4: arithmetic right long by 40 fills with sign, C = sign
    drive(2'd0, 1'b0, 2'd2, 1'b1, 3'd0, 32'd40, 1'b0, 32'h8000_0000, 5'b00000, "R4");
    // R4: logical left byte by 9 shifts past the width, C = 0
    drive(2'd1, 1'b1, 2'd0, 1'b1, 3'd0, 32'd9, 1'b0, 32'h0000_00FF, 5'b10001, "R4");
    idle();
    // R5: zero register count keeps X, clears C
    drive(2'd1, 1'b1, 2'd2, 1'b1, 3'd0, 32'd64, 1'b0, 32'h8000_0000, 5'b10001, "R5");
    drive(2'd0, 1'b0, 2'd0, 1'b1, 3'd0, 32'd0, 1'b0, 32'h1234_5600, 5'b00001, "R5");
    // R3: all-ones byte shifted 8 left loses its sign -> V
    drive(2'd0, 1'b1, 2'd0, 1'b0, 3'd0, 32'd0, 1'b0, 32'h0000_00FF, 5'b00000, "R3");
    // R3: 0xFF << 3 keeps sign at every step -> no V
    drive(2'd0, 1'b1, 2'd0, 1'b0, 3'd3, 32'd0, 1'b0, 32'h0000_00FF, 5'b00000, "R3");
    // R3: logical left never sets V
    drive(2'd1, 1'b1, 2'd0, 1'b0, 3'd1, 32'd0, 1'b0, 32'h0000_0040, 5'b00000, "R3");
    // R6: rotate through X by 9 on a byte reduces to 0 -> C = old X
    drive(2'd2, 1'b1, 2'd0, 1'b1, 3'd0, 32'd9, 1'b0, 32'h0000_005A, 5'b10000, "R6");
    drive(2'd2, 1'b0, 2'd1, 1'b1, 3'd0, 32'd34, 1'b0, 32'h0000_1234, 5'b00001, "R6");
    drive(2'd2, 1'b1, 2'd0, 1'b0, 3'd1, 32'd0, 1'b0, 32'h0000_0080, 5'b10000, "R6");
    drive(2'd2, 1'b0, 2'd2, 1'b1, 3'd0, 32'd33, 1'b0, 32'hDEAD_BEEF, 5'b10000, "R6");
    // R7: plain rotate by the width, zero count, and X preserved
    drive(2'd3, 1'b1, 2'd1, 1'b1, 3'd0, 32'd16, 1'b0, 32'h0000_8001, 5'b10000, "R7");
    drive(2'd3, 1'b0, 2'd0, 1'b1, 3'd0, 32'd0, 1'b0, 32'h0000_0081, 5'b10001, "R7");
    drive(2'd3, 1'b0, 2'd0, 1'b0, 3'd1, 32'd0, 1'b0, 32'h0000_0001, 5'b00000, "R7");
    // R8: long with count 63 costs 8 + 126
    drive(2'd1, 1'b0, 2'd2, 1'b1, 3'd0, 32'd63, 1'b0, 32'hFFFF_FFFF, 5'b00000, "R8");
    // R9: memory form ignores count fields and keeps upper half
    drive(2'd0, 1'b0, 2'd0, 1'b1, 3'd5, 32'd17, 1'b1, 32'hABCD_8001, 5'b00000, "R9");
    drive(2'd3, 1'b1, 2'd2, 1'b0, 3'd3, 32'd0, 1'b1, 32'h1234_8000, 5'b10000, "R9");
    // R10: byte result zero with upper bits live; size 3 acts as long
    drive(2'd1, 1'b1, 2'd0, 1'b0, 3'd1, 32'd0, 1'b0, 32'hFFFF_FF80, 5'b00000, "R10");
    drive(2'd1, 1'b0, 2'd3, 1'b0, 3'd4, 32'd0, 1'b0, 32'hF000_0000, 5'b00000, "R10");
    idle();
    idle();

    for (int i = 0; i < 400; i++) begin
      drive(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 3'($urandom),
            $urandom, (($urandom % 8) == 0), $urandom, 5'($urandom), "R1_R10");
      if (($urandom % 5) == 0) idle();
    end
    idle();
    idle();
    idle();

    checks++;
    if (q_res.size() != 0) begin
      errors++;
      $display("FAIL R11: pending results actual %0d expected 0", q_res.size());
    end
    finish_run();
  end
endmodule